// File: doc/BRIEF.md
# SPI Byte Port with Sequenced Status Flags

This block is an 8-bit serial peripheral port that can act as bus master or as a slave. It supports one clocking arrangement only. The clock idles low, data leaves most significant bit first, the receiver samples on the rising clock edge, and the transmitter moves to the next bit on the falling edge. A processor reaches it through two registers: a control/status register and a data register. As master, the block makes its own serial clock by dividing the system clock. As slave, it follows an external clock while its active-low select input is held low.

Two sticky flags report progress. The completion flag goes up when the eighth bit has been sampled. The collision flag goes up when software writes the data register while a byte is still moving; that write is dropped and the byte in flight is not affected. Both flags clear only through a fixed order of accesses: first a status read, which arms the clear, then a data-register read, which performs it. The data read clears the completion flag only if that flag was already set when the status was read. A data write placed between the two reads does not cancel the armed clear. A slave that has not been given a new byte sends back the byte it last received.

Top module: `spi_flag_port`

## Requirements
- R1: After reset, both registers read 0x00, the level output is low, SCK is low and the MISO enable is low.
- R2: The control register holds enable in bit 0, master in bit 1 and divider select `d` in bits 3:2. A data write to an idle, enabled master starts eight SCK pulses, each with a period of 2^(d+1) system clocks. SCK is low whenever no byte is in progress.
- R3: The master drives MOSI most significant bit first, and each bit is stable before its rising SCK edge. It samples MISO on each rising edge. Once the byte is complete, a data read returns the received byte.
- R4: The status register shows the completion flag in bit 7, the collision flag in bit 6 and the control field in bits 3:0. The completion flag and the level output rise on the eighth rising SCK edge, not earlier.
- R5: A data write while a byte is in progress sets the collision flag. The byte already shifting goes out unchanged.
- R6: A status read followed by a data read, made after the completion flag is set, clears both flags.
- R7: A status read followed by a data read, made while a byte is still in progress, clears only the collision flag. The completion flag then sets at the end of the byte.
- R8: A data write between the status read and the data read leaves both flags set, and the armed clear stays pending. The data read that follows still clears both flags.
- R9: A data read without a status read before it leaves both flags unchanged.
- R10: An enabled slave with select low drives MISO (enable high) with the byte last written to it, most significant bit first. It receives MOSI, and the received byte is readable once the byte completes.
- R11: A slave that has had no data write since its last byte sends back on MISO the byte it last received.
- R12: A slave with select high holds the MISO enable low, ignores SCK pulses, does not set the completion flag and keeps its last received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regSel | input | 1 | Register select: 0 control/status, 1 data |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (acts on flag sequencing) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected register |
| irq | output | 1 | Level output, follows the completion flag |
| sckOut | output | 1 | Serial clock generated in master mode |
| mosiOut | output | 1 | Master serial data out |
| misoIn | input | 1 | Master serial data in |
| sckIn | input | 1 | Serial clock in slave mode |
| mosiIn | input | 1 | Slave serial data in |
| ssN | input | 1 | Active-low slave select |
| misoOut | output | 1 | Slave serial data out |
| misoOe | output | 1 | Slave MISO output enable |

## Verification
The hardest state to reach from the ports is an armed clear that meets a byte in mid-flight. In that case the status read sees the completion flag still low, so the data read that follows must spare that flag. The stimulus uses the slowest divider to keep each byte long. During that window it forces a collision, then issues the status read and the data read, and only after that lets the transfer finish. The sticky-write case is reached differently. The master is disabled after a byte with a collision, so the data write placed inside the armed sequence loads the port without starting a new transfer.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  // control field layout: the status read returns this field in its low bits
  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_MST_BIT = 1;
  localparam int CTRL_DIV_LSB = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic busy;      // a byte is in progress
    logic sample;    // rising serial clock: capture the input bit
    logic shiftOut;  // falling serial clock: present the next output bit
    logic done;      // last bit of the byte is being sampled
  } spi_strobe_t;
endpackage

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CTRL_W     = 2 + DIV_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              sckIn,
  input  logic              ssN,
  output logic [CTRL_W-1:0] ctrlQ,
  output logic              spif,
  output logic              wcol,
  output logic              sckOut,
  output logic              slaveActive,
  output spi_strobe_t       stb
);
  localparam int CNT_W  = $clog2(DATA_W);
  localparam int HALF_W = (1 << DIV_W) - 1;

  logic              ctrlWr, dataWr, statRd, dataRd;
  logic              enable, master;
  logic [DIV_W-1:0]  divSel;
  logic [SYNC_STAGES-1:0] sckSync, ssSync;
  logic              sckPrev, sckS, ssS;
  logic              running, sckQ, halfLast, start, mRise, mFall;
  logic [HALF_W-1:0] halfCnt;
  logic [HALF_W:0]   halfLen;
  logic [CNT_W-1:0]  bitCnt;
  logic              armed, armSpif, busy, sample, shiftOut, done;

  assign ctrlWr = regWr && !regSel;
  assign dataWr = regWr && regSel;
  assign statRd = regRd && !regSel;
  assign dataRd = regRd && regSel;

  assign enable = ctrlQ[CTRL_EN_BIT];
  assign master = ctrlQ[CTRL_MST_BIT];
  assign divSel = ctrlQ[CTRL_DIV_LSB +: DIV_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= ctrlWrData;
  end

  // slave input synchronisers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSync <= '0;
      ssSync  <= '1;
      sckPrev <= 1'b0;
    end else begin
      sckSync <= {sckSync[SYNC_STAGES-2:0], sckIn};
      ssSync  <= {ssSync[SYNC_STAGES-2:0], ssN};
      sckPrev <= sckS;
    end
  end
  assign sckS        = sckSync[SYNC_STAGES-1];
  assign ssS         = ssSync[SYNC_STAGES-1];
  assign slaveActive = enable && !master && !ssS;

  // master clock generation
  assign halfLen  = (HALF_W + 1)'(1) << divSel;
  assign halfLast = ({1'b0, halfCnt} == halfLen - 1'b1);
  assign busy     = running || (slaveActive && bitCnt != '0);
  assign start    = dataWr && !busy && enable && master;
  assign mRise    = running && halfLast && !sckQ;
  assign mFall    = running && halfLast && sckQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      sckQ    <= 1'b0;
      halfCnt <= '0;
    end else if (start) begin
      running <= 1'b1;
      sckQ    <= 1'b0;
      halfCnt <= '0;
    end else if (running) begin
      halfCnt <= halfLast ? '0 : halfCnt + 1'b1;
      if (halfLast) sckQ <= !sckQ;
      // a falling edge with the bit counter wrapped ends the byte
      if (mFall && bitCnt == '0) running <= 1'b0;
    end
  end
  assign sckOut = sckQ;

  assign sample   = mRise || (slaveActive && sckS && !sckPrev);
  assign shiftOut = mFall || (slaveActive && !sckS && sckPrev);
  assign done     = sample && (bitCnt == CNT_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (start || (!master && !slaveActive)) bitCnt <= '0;
    else if (sample) bitCnt <= done ? '0 : bitCnt + 1'b1;
  end

  // flag sequencing: status read arms, data read clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      armSpif <= 1'b0;
      spif    <= 1'b0;
      wcol    <= 1'b0;
    end else begin
      if (statRd) begin
        armed   <= 1'b1;
        armSpif <= spif;
      end else if (dataRd) begin
        armed   <= 1'b0;
      end
      if (done) spif <= 1'b1;
      else if (dataRd && armed && armSpif) spif <= 1'b0;
      if (dataWr && busy) wcol <= 1'b1;
      else if (dataRd && armed) wcol <= 1'b0;
    end
  end

  assign stb = '{busy: busy, sample: sample, shiftOut: shiftOut, done: done};
endmodule

// File: rtl/spi_flag_datapath.sv
module spi_flag_datapath
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  spi_strobe_t       stb,
  input  logic              regSel,
  input  logic              regWr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              master,
  input  logic              misoIn,
  input  logic              mosiIn,
  input  logic [CTRL_W-1:0] ctrlQ,
  input  logic              spif,
  input  logic              wcol,
  output logic [DATA_W-1:0] rdData,
  output logic              dataOut
);
  localparam int PAD_W = DATA_W - 2 - CTRL_W;

  logic [DATA_W-1:0] shiftReg, rxBuf, nextShift;
  logic              outBit, inBit, load;

  assign load      = regWr && regSel && !stb.busy;
  assign inBit     = master ? misoIn : mosiIn;
  assign nextShift = {shiftReg[DATA_W-2:0], inBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      rxBuf    <= '0;
      outBit   <= 1'b0;
    end else begin
      if (stb.sample) begin
        shiftReg <= nextShift;
        if (stb.done) rxBuf <= nextShift;
      end else if (load) begin
        shiftReg <= wrData;
        outBit   <= wrData[DATA_W-1];
      end
      // after the last bit the register holds the received byte,
      // which is what an unloaded slave sends next
      if (stb.shiftOut) outBit <= shiftReg[DATA_W-1];
    end
  end

  assign dataOut = outBit;
  assign rdData  = regSel ? rxBuf : {spif, wcol, {PAD_W{1'b0}}, ctrlQ};
endmodule

// File: rtl/spi_flag_port.sv
module spi_flag_port
  import spi_flag_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq,
  output logic              sckOut,
  output logic              mosiOut,
  input  logic              misoIn,
  input  logic              sckIn,
  input  logic              mosiIn,
  input  logic              ssN,
  output logic              misoOut,
  output logic              misoOe
);
  localparam int CTRL_W = 2 + DIV_W;

  spi_strobe_t       stb;
  logic [CTRL_W-1:0] ctrlQ;
  logic              spif, wcol, dataOut, slaveActive;

  spi_flag_ctrl #(.DATA_W(DATA_W), .DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .ctrlWrData(wrData[CTRL_W-1:0]), .sckIn(sckIn), .ssN(ssN),
    .ctrlQ(ctrlQ), .spif(spif), .wcol(wcol), .sckOut(sckOut),
    .slaveActive(slaveActive), .stb(stb)
  );

  spi_flag_datapath #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .regSel(regSel), .regWr(regWr),
    .wrData(wrData), .master(ctrlQ[CTRL_MST_BIT]), .misoIn(misoIn),
    .mosiIn(mosiIn), .ctrlQ(ctrlQ), .spif(spif), .wcol(wcol),
    .rdData(rdData), .dataOut(dataOut)
  );

  assign irq     = spif;
  assign mosiOut = ctrlQ[CTRL_MST_BIT] ? dataOut : 1'b0;
  assign misoOut = dataOut;
  assign misoOe  = slaveActive;
endmodule

// File: rtl/spi_flag_checker.sv
module spi_flag_checker (
  input logic clk,
  input logic rstN,
  input logic regSel,
  input logic regWr,
  input logic regRd,
  input logic ssN,
  input logic misoOe,
  input logic sckOut,
  input logic spif,
  input logic wcol,
  input logic busy
);
  assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sckOut);

  assert_wcol_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regSel && busy) |=> wcol);

  assert_spif_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spif) |-> $past(regRd && regSel));

  assert_wcol_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wcol) |-> $past(regRd && regSel));

  assert_wcol_keep_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wcol && regWr && regSel && !regRd) |=> wcol);

  assert_oe_off_R12: assert property (@(posedge clk) disable iff (!rstN)
    (ssN && $past(ssN) && $past(ssN, 2)) |-> !misoOe);
endmodule

bind spi_flag_port spi_flag_checker i_checker (
  .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
  .ssN(ssN), .misoOe(misoOe), .sckOut(sckOut), .spif(spif), .wcol(wcol),
  .busy(stb.busy)
);

// File: tb/test_spi_flag_port.sv
module test_spi_flag_port;
  logic       clk = 1'b0, rstN = 1'b0;
  logic       regSel = 1'b0, regWr = 1'b0, regRd = 1'b0;
  logic [7:0] wrData = '0;
  logic       misoIn = 1'b0, sckIn = 1'b0, mosiIn = 1'b0, ssN = 1'b1;
  wire  [7:0] rdData;
  wire        irq, sckOut, mosiOut, misoOut, misoOe;

  int nChecks = 0, nFails = 0;

  spi_flag_port i_spi_flag_port (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWr(regWr), .regRd(regRd),
    .wrData(wrData), .rdData(rdData), .irq(irq), .sckOut(sckOut),
    .mosiOut(mosiOut), .misoIn(misoIn), .sckIn(sckIn), .mosiIn(mosiIn),
    .ssN(ssN), .misoOut(misoOut), .misoOe(misoOe)
  );

  always #10 clk = !clk;

  // serial-side model of a slave attached to the master
  int         riseCnt = 0, lastRise = -1, minPer = 1000, maxPer = 0, cyc = 0;
  logic [7:0] mosiCap = '0, rxPat = '0;
  logic       lastLowMosi = 1'b0, prevSck = 1'b0, irqAt7 = 1'b0, irqAt8 = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (sckOut && !prevSck) begin
      riseCnt++;
      mosiCap = {mosiCap[6:0], lastLowMosi};
      if (lastRise >= 0) begin
        if (cyc - lastRise < minPer) minPer = cyc - lastRise;
        if (cyc - lastRise > maxPer) maxPer = cyc - lastRise;
      end
      lastRise = cyc;
      if (riseCnt == 7) irqAt7 = irq;
      if (riseCnt == 8) irqAt8 = irq;
    end
    if (!sckOut) lastLowMosi = mosiOut;
    if (riseCnt < 8) misoIn = rxPat[7 - riseCnt];
    prevSck = sckOut;
  end

  task automatic monClear(input logic [7:0] rx);
    riseCnt = 0; lastRise = -1; minPer = 1000; maxPer = 0;
    mosiCap = '0; rxPat = rx; misoIn = rx[7]; irqAt7 = 1'b0; irqAt8 = 1'b0;
  endtask

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; regRd = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic masterOne(input int dv, input logic [7:0] tx);
    logic [7:0] rx, v, ctl;
    int h;
    h = 1 << dv;
    rx = 8'(tx * 37 + 11);
    ctl = 8'((dv << 2) | 3);
    @(posedge clk); #1 monClear(rx);
    regWrite(1'b1, tx);
    repeat (16 * h + 6) @(negedge clk);
    check("R3 mosi byte", mosiCap, tx);
    check("R2 pulse count", riseCnt, 8);
    check("R2 min period", minPer, 2 * h);
    check("R2 max period", maxPer, 2 * h);
    check("R4 irq low at 7th edge", irqAt7, 0);
    check("R4 irq high at 8th edge", irqAt8, 1);
    check("R2 sck idle", sckOut, 0);
    regRead(1'b0, v); check("R4 status after byte", v, 8'h80 | ctl);
    regRead(1'b1, v); check("R3 received byte", v, rx);
    regRead(1'b0, v); check("R6 flags cleared", v, ctl);
  endtask

  task automatic slaveRun(input logic [7:0] mo, output logic [7:0] mi);
    @(negedge clk); ssN = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 7; i >= 0; i--) begin
      mosiIn = mo[i];
      repeat (6) @(negedge clk);
      mi[i] = misoOut;
      if (i == 7) check("R10 miso enabled", misoOe, 1);
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (8) @(negedge clk);
    ssN = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] v, mi, prev, w;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check("R1 sck low", sckOut, 0);
    check("R1 miso enable low", misoOe, 0);
    check("R1 irq low", irq, 0);
    regRead(1'b0, v); check("R1 status zero", v, 0);
    regRead(1'b1, v); check("R1 data zero", v, 0);

    // R2 R3 R4 R6: exhaustive bytes at the fastest divider, a sweep at the others
    regWrite(1'b0, 8'h03);
    for (int b = 0; b < 256; b++) masterOne(0, 8'(b));
    for (int dv = 1; dv < 4; dv++) begin
      regWrite(1'b0, 8'((dv << 2) | 3));
      for (int k = 0; k < 12; k++) masterOne(dv, 8'(k * 23 + dv));
    end

    // R5 collision while shifting, then R6 clear after completion (divider 16)
    regWrite(1'b0, 8'h0F);
    @(posedge clk); #1 monClear(8'h0F);
    regWrite(1'b1, 8'hA5);
    repeat (40) @(negedge clk);
    regWrite(1'b1, 8'h3C);
    repeat (100) @(negedge clk);
    check("R5 byte in flight unchanged", mosiCap, 8'hA5);
    regRead(1'b0, v); check("R5 collision and completion set", v, 8'hCF);
    regRead(1'b1, v); check("R5 received byte intact", v, 8'h0F);
    regRead(1'b0, v); check("R6 both flags cleared", v, 8'h0F);

    // R7 clear sequence during the byte clears only the collision flag
    @(posedge clk); #1 monClear(8'h66);
    regWrite(1'b1, 8'h81);
    repeat (20) @(negedge clk);
    regWrite(1'b1, 8'h18);
    regRead(1'b0, v); check("R7 collision before completion", v, 8'h4F);
    regRead(1'b1, v);
    regRead(1'b0, v); check("R7 collision cleared mid byte", v, 8'h0F);
    repeat (120) @(negedge clk);
    check("R7 completion sets later", irq, 1);
    regRead(1'b0, v); check("R7 status after byte", v, 8'h8F);
    regRead(1'b1, v); check("R7 received byte", v, 8'h66);
    regRead(1'b0, v); check("R7 completion cleared", v, 8'h0F);
    regRead(1'b1, v);

    // R8 data write inside the armed sequence
    @(posedge clk); #1 monClear(8'h11);
    regWrite(1'b1, 8'hC3);
    repeat (30) @(negedge clk);
    regWrite(1'b1, 8'h00);
    repeat (110) @(negedge clk);
    regWrite(1'b0, 8'h0E);
    regRead(1'b0, v); check("R8 flags before write", v, 8'hCE);
    regWrite(1'b1, 8'h77);
    regRead(1'b0, v); check("R8 write leaves flags", v, 8'hCE);
    regWrite(1'b1, 8'h55);
    check("R8 no transfer started", irq, 1);
    regRead(1'b1, v);
    regRead(1'b0, v); check("R8 armed clear survives write", v, 8'h0E);
    regRead(1'b1, v);

    // R9 data read without status read
    regWrite(1'b0, 8'h0F);
    @(posedge clk); #1 monClear(8'h22);
    regWrite(1'b1, 8'h5A);
    repeat (30) @(negedge clk);
    regWrite(1'b1, 8'h01);
    repeat (110) @(negedge clk);
    regRead(1'b1, v); check("R9 data read value", v, 8'h22);
    regRead(1'b0, v); check("R9 flags kept", v, 8'hCF);
    regRead(1'b1, v);
    regRead(1'b0, v); check("R9 later sequence clears", v, 8'h0F);

    // R10 R11 slave mode
    regWrite(1'b0, 8'h01);
    regWrite(1'b1, 8'h96);
    slaveRun(8'h5A, mi);
    check("R10 slave sends loaded byte", mi, 8'h96);
    regRead(1'b0, v); check("R10 slave completion", v, 8'h81);
    regRead(1'b1, v); check("R10 slave received byte", v, 8'h5A);
    regRead(1'b0, v); check("R10 slave flags cleared", v, 8'h01);
    prev = 8'h5A;
    for (int k = 0; k < 16; k++) begin
      w = 8'(k * 17 + 3);
      if (k % 4 == 3) begin
        regWrite(1'b1, 8'(~w));
        slaveRun(w, mi);
        check("R10 slave sends new load", mi, 8'(~w));
      end else begin
        slaveRun(w, mi);
        check("R11 slave echoes last received", mi, prev);
      end
      regRead(1'b0, v);
      regRead(1'b1, v); check("R10 slave received", v, w);
      prev = w;
    end

    // R12 deselected slave
    regRead(1'b0, v);
    regRead(1'b1, v);
    for (int i = 0; i < 8; i++) begin
      mosiIn = i[0];
      repeat (6) @(negedge clk);
      check("R12 miso enable low", misoOe, 0);
      sckIn = 1'b1;
      repeat (6) @(negedge clk);
      sckIn = 1'b0;
    end
    repeat (6) @(negedge clk);
    check("R12 no completion", irq, 0);
    regRead(1'b0, v); check("R12 status unchanged", v, 8'h01);
    regRead(1'b1, v); check("R12 received byte kept", v, prev);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule